// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is the master side of a synchronous serial link. Software-side logic writes words into an 8-entry transmit queue. Each word becomes one frame on the serial data output, sent most significant bit first. The port drives its own serial clock and a frame strobe for the whole frame. While a frame is sent, the bits arriving on the receive line are shifted in. The received word goes into an 8-entry receive queue. Frames follow each other for as long as the port is enabled and the transmit queue holds data.

A control register sets the serial clock idle level and the clock phase. The phase decides whether the long idle gap of the clock falls at the start or at the end of the frame. The same register enables an internal loopback and the two queue-level interrupts. It also chooses the timing source: either the system clock divided by 2×(N+1), or the edges of an external clock input. A mode register holds the divider N, the frame length and the port enable.

Top module: `ssp_master`

## Requirements
- R1: After reset both registers read 0. `sclk_o`, `sfrm_o`, `txd_o`, `tx_irq_o` and `rx_irq_o` are 0, `rx_empty_o` is 1 and `pad_oe_o` is 1.
- R2: Register 0 is the control register. Bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, bit 2 loopback, bit 3 clock polarity, bit 4 clock phase and bit 5 external clock select. Bits 15..6 ignore writes and read 0. Register 1 is the mode register: bits 7..0 hold the divider N, bits 11..8 hold the frame length minus one, bit 12 is the enable, and bits 15..13 read 0.
- R3: While no frame is in progress, `sclk_o` rests at the polarity bit.
- R4: With phase 0 the clock stays idle for two half-bit periods after `sfrm_o` rises and for one half-bit period after its last active half. With phase 1 these are one and two half-bit periods.
- R5: A frame sends the word's low n bits, most significant first. n is the length field plus one; field values 0..2 give n = 4. The received bits are pushed right-aligned, with zeros above, when the frame ends. Receive data is sampled on the same clock edge on which a slave samples the transmit data.
- R6: `rx_irq_o` is 1 when its enable is set and the receive queue holds 3 or more words. With the enable cleared it is 0.
- R7: `tx_irq_o` is 1 when its enable is set and the transmit queue holds 4 or fewer words. With the enable cleared it is 0.
- R8: A frame starts only when the enable bit is 1 and the transmit queue is not empty. Queued words are sent as consecutive frames.
- R9: In loopback the transmit data feeds the receiver. `pad_oe_o`, `sclk_o`, `sfrm_o` and `txd_o` stay 0, and the received word equals the sent word.
- R10: With the internal source selected, one half-bit period lasts N+1 system clock cycles.
- R11: With the external source selected, every edge of `ext_clk_i` ends one half-bit period, after synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the internal rate reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| tx_push_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 16 | Word to transmit |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Drop the head of the receive queue |
| rx_data_o | output | 16 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| ext_clk_i | input | 1 | External timing clock, at most a quarter of `clk_i` |
| rxd_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Serial clock |
| sfrm_o | output | 1 | Frame strobe, high for the whole frame |
| txd_o | output | 1 | Serial transmit data |
| pad_oe_o | output | 1 | Serial pins driven; 0 in loopback |
| tx_irq_o | output | 1 | Transmit queue level interrupt |
| rx_irq_o | output | 1 | Receive queue level interrupt |

## Verification
Frames are run under four settings. Phase 0 with idle-low clock, 8-bit words and N=1 separates the leading and trailing idle lengths and fixes the half period. Phase 1 with idle-high clock, 16-bit words and N=2 reverses those lengths and checks the sampling edge. A clamped 4-bit frame shows truncation and right alignment. A loopback frame must show quiet pins and give a received word equal to the sent word. An external-clock frame shows that the half period follows `ext_clk_i` and not the divider. Queue pushes and pops walk the interrupt thresholds through both sides of each limit.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW    = 16;
  localparam int DIV_W = 8;
  localparam int SZ_W  = $clog2(DW);

  typedef struct packed {
    logic ext_clk;
    logic phase;
    logic polarity;
    logic loopback;
    logic tx_ie;
    logic rx_ie;
  } ctrl_t;

  typedef struct packed {
    logic             en;
    logic [SZ_W-1:0]  size_m1;
    logic [DIV_W-1:0] div;
  } mode_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (do_push) begin
      mem_q[wr_q] <= data_i;
    end
  end
endmodule

// File: rtl/ssp_tick.sv
module ssp_tick #(
  parameter int DIV_W = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  logic [SYNC:0]      sync_q;
  logic [DIV_W-1:0]   cnt_q;
  logic               int_tick, ext_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ext_clk_i;
  end

  // synchroniser stages plus one edge-detect stage
  for (genvar g = 1; g <= SYNC; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign ext_edge = sync_q[SYNC] ^ sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign int_tick = (cnt_q == div_i) && !restart_i;
  assign tick_o   = ext_sel_i ? ext_edge : int_tick;
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame
  import ssp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic [DW-1:0]   word_i,
  input  logic [SZ_W-1:0] msb_i,
  input  logic            phase_i,
  input  logic            polarity_i,
  input  logic            rx_bit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   rx_word_o,
  output logic            sclk_o,
  output logic            sfrm_o,
  output logic            txd_o
);
  localparam int HW = $clog2(2 * DW + 2) + 1;

  logic            busy_q, done_q, phase_q;
  logic [HW-1:0]   half_q;
  logic [DW-1:0]   tx_q, rx_q;
  logic [SZ_W-1:0] msb_q;

  logic [HW-1:0]   span, last_half, lead, rel, idx_raw, hm1;
  logic [SZ_W-1:0] idx;
  logic            active;

  // span = 2n half periods of clocking, frame = span + 2 halves
  assign span      = HW'(({1'b0, msb_q} + 1'b1)) << 1;
  assign last_half = span + HW'(1);
  assign lead      = phase_q ? HW'(1) : HW'(2);
  assign rel       = half_q - lead;
  assign active    = busy_q && (half_q >= lead) && (rel < span) && !rel[0];

  assign hm1     = half_q - HW'(1);
  assign idx_raw = (half_q == '0) ? '0 : (hm1 >> 1);
  assign idx     = (idx_raw > HW'(msb_q)) ? msb_q : idx_raw[SZ_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      half_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      msb_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          half_q  <= '0;
          tx_q    <= word_i;
          rx_q    <= '0;
          msb_q   <= msb_i;
          phase_q <= phase_i;
        end
      end else if (tick_i) begin
        if (half_q == last_half) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          half_q <= half_q + HW'(1);
          // entering an even half >= 2 is the sampling edge
          if (half_q[0] && (half_q < span)) rx_q <= {rx_q[DW-2:0], rx_bit_i};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_q;
  assign sclk_o    = polarity_i ^ active;
  assign sfrm_o    = busy_q;
  assign txd_o     = busy_q && tx_q[msb_q - idx];
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int RX_THR = 3,
  parameter int TX_THR = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_full_o,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_empty_o,
  input  logic          ext_clk_i,
  input  logic          rxd_i,
  output logic          sclk_o,
  output logic          sfrm_o,
  output logic          txd_o,
  output logic          pad_oe_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o
);
  ctrl_t           ctrl_q;
  mode_t           mode_q;
  logic [DW-1:0]   tx_head, rx_word;
  logic [CW-1:0]   tx_count, rx_count;
  logic            tx_empty, busy, done, start, tick;
  logic            sclk_int, sfrm_int, txd_int, rx_bit;
  logic [SZ_W-1:0] msb_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        2'd0:    ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        2'd1:    mode_q <= mode_t'(reg_wdata_i[MODE_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = DW'(ctrl_q);
      2'd1:    reg_rdata_o = DW'(mode_q);
      default: reg_rdata_o = '0;
    endcase
  end

  // frames shorter than 4 bits are not supported
  assign msb_eff = (mode_q.size_m1 < SZ_W'(3)) ? SZ_W'(3) : mode_q.size_m1;
  assign start   = mode_q.en && !tx_empty && !busy;
  assign rx_bit  = ctrl_q.loopback ? txd_int : rxd_i;

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (start),
    .data_o  (tx_head),
    .count_o (tx_count),
    .full_o  (tx_full_o),
    .empty_o (tx_empty)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (done),
    .data_i  (rx_word),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .count_o (rx_count),
    .full_o  (),
    .empty_o (rx_empty_o)
  );

  ssp_tick #(.DIV_W(DIV_W), .SYNC(2)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_sel_i (ctrl_q.ext_clk),
    .div_i     (mode_q.div),
    .restart_i (start),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  ssp_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .start_i    (start),
    .word_i     (tx_head),
    .msb_i      (msb_eff),
    .phase_i    (ctrl_q.phase),
    .polarity_i (ctrl_q.polarity),
    .rx_bit_i   (rx_bit),
    .busy_o     (busy),
    .done_o     (done),
    .rx_word_o  (rx_word),
    .sclk_o     (sclk_int),
    .sfrm_o     (sfrm_int),
    .txd_o      (txd_int)
  );

  assign pad_oe_o = !ctrl_q.loopback;
  assign sclk_o   = pad_oe_o && sclk_int;
  assign sfrm_o   = pad_oe_o && sfrm_int;
  assign txd_o    = pad_oe_o && txd_int;
  assign tx_irq_o = ctrl_q.tx_ie && (tx_count <= CW'(TX_THR));
  assign rx_irq_o = ctrl_q.rx_ie && (rx_count >= CW'(RX_THR));
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk
  import ssp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input ctrl_t         ctrl_i,
  input logic          busy_i,
  input logic          tx_empty_i,
  input logic          tx_full_i,
  input logic          rx_empty_i,
  input logic          tx_irq_i,
  input logic          rx_irq_i,
  input logic          sclk_i,
  input logic          sfrm_i,
  input logic          pad_oe_i,
  input logic [CW-1:0] rx_cnt_i,
  input logic          rx_pop_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_rdata_i
);
  p_sclk_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_i && !sfrm_i) |-> (sclk_i == ctrl_i.polarity));

  p_start_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!tx_empty_i));

  p_rx_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && (rx_cnt_i < CW'(DEPTH)) && !rx_pop_i) |=> (rx_cnt_i == $past(rx_cnt_i) + 1'b1));

  p_rx_empty_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |-> !rx_irq_i);

  p_tx_full_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_irq_i);

  p_loop_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pad_oe_i) |-> (!sfrm_i && !sclk_i));

  p_ctrl_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_i[DW-1:CTRL_W] == '0));
endmodule

bind ssp_master ssp_master_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_q),
  .busy_i      (busy),
  .tx_empty_i  (tx_empty),
  .tx_full_i   (tx_full_o),
  .rx_empty_i  (rx_empty_o),
  .tx_irq_i    (tx_irq_o),
  .rx_irq_i    (rx_irq_o),
  .sclk_i      (sclk_o),
  .sfrm_i      (sfrm_o),
  .pad_oe_i    (pad_oe_o),
  .rx_cnt_i    (rx_count),
  .rx_pop_i    (rx_pop_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_i (reg_rdata_o)
);

// File: tb/test_ssp_master.sv
module test_ssp_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tx_push = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_full;
  logic        rx_pop = 1'b0;
  logic [15:0] rx_data;
  logic        rx_empty;
  logic        ext_clk = 1'b0;
  logic        rxd = 1'b0;
  logic        sclk, sfrm, txd, pad_oe, tx_irq, rx_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] q_tx[$], q_reply[$], q_rx[$];
  int  nbits = 8;
  bit  pol = 1'b0;
  bit  pha = 1'b0;
  int  exp_lead = 0, exp_tail = 0, exp_half = 0;
  bit  chk_edges = 1'b0, chk_half = 1'b0;
  int  nframes = 0;

  always #10 clk = ~clk;

  ssp_master i_ssp_master (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .ext_clk_i(ext_clk), .rxd_i(rxd),
    .sclk_o(sclk), .sfrm_o(sfrm), .txd_o(txd), .pad_oe_o(pad_oe),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] mask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic push_word(input logic [15:0] w);
    @(negedge clk);
    tx_push = 1'b1; tx_data = w;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  // driver: expected items go to the scoreboard queues
  task automatic send(input logic [15:0] w, input logic [15:0] reply);
    q_tx.push_back(w & mask(nbits));
    q_reply.push_back(reply);
    q_rx.push_back(reply & mask(nbits));
    push_word(w);
  endtask

  task automatic send_lb(input logic [15:0] w);
    q_rx.push_back(w & mask(nbits));
    push_word(w);
  endtask

  task automatic pop_chk(input string req);
    @(negedge clk);
    if (q_rx.size() == 0) check(req, 32'(rx_empty), 32'd0);
    else check(req, {16'd0, rx_data}, {16'd0, q_rx.pop_front()});
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (!rx_empty) pop_chk(req);
    check(req, q_rx.size(), 0);
  endtask

  // external clock: toggles every 8 system clocks
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  // monitor: slave model on the serial pins
  initial begin
    bit prev_sfrm = 1'b0, prev_sclk = 1'b0;
    bit seen_act = 1'b0, pulse_done = 1'b0;
    int bits = 0, lead = 0, idle_run = 0, act_run = 0;
    logic [15:0] cap = '0, reply = '0;
    bit act;
    forever begin
      @(negedge clk);
      if (sfrm && !prev_sfrm) begin
        bits = 0; cap = '0; lead = 0; idle_run = 0; act_run = 0;
        seen_act = 1'b0; pulse_done = 1'b0;
        reply = (q_reply.size() != 0) ? q_reply.pop_front() : 16'h0;
        rxd = reply[nbits-1];
        nframes++;
      end
      if (sfrm) begin
        act = sclk ^ pol;
        if (!act) begin
          if (!seen_act) lead++;
          if (seen_act) pulse_done = 1'b1;
          idle_run++;
        end else begin
          seen_act = 1'b1;
          idle_run = 0;
          if (!pulse_done) act_run++;
        end
        if (prev_sfrm && (sclk != prev_sclk) && (pha ? !act : act)) begin
          cap = {cap[14:0], txd};
          bits++;
          if (bits < nbits) rxd = reply[nbits-1-bits];
        end
      end
      if (!sfrm && prev_sfrm) begin
        check("R5 bits per frame", bits, nbits);
        if (q_tx.size() == 0) check("R5 unexpected frame", 1, 0);
        else check("R5 transmitted word", {16'd0, cap}, {16'd0, q_tx.pop_front()});
        if (chk_edges) begin
          check("R4 leading idle", lead, exp_lead);
          check("R4 trailing idle", idle_run, exp_tail);
        end
        if (chk_half) check("R10 R11 half period", act_run, exp_half);
      end
      prev_sfrm = sfrm;
      prev_sclk = sclk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl reset", d, 0);
    rd(2'd1, d); check("R1 mode reset", d, 0);
    check("R1 pins", {sclk, sfrm, txd, pad_oe}, 4'b0001);
    check("R1 irqs and empty", {tx_irq, rx_irq, rx_empty}, 3'b001);

    // R2 register fields
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 ctrl reserved bits", d, 16'h003F);
    wr(2'd1, 16'hFFFF); rd(2'd1, d); check("R2 mode reserved bits", d, 16'h1FFF);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0003); rd(2'd0, d); check("R2 ctrl readback", d, 16'h0003);

    // R7 / R8: queue with port disabled, 8-bit frames, N=1
    nbits = 8; pol = 0; pha = 0;
    wr(2'd1, 16'h0701);
    check("R7 tx irq empty queue", tx_irq, 1);
    send(16'h00A5, 16'h003C);
    send(16'h0F0F, 16'h00C3);
    send(16'h0081, 16'h007E);
    send(16'h00FF, 16'h0001);
    check("R7 tx irq at 4", tx_irq, 1);
    send(16'h0012, 16'h0080);
    check("R7 tx irq above 4", tx_irq, 0);
    wr(2'd0, 16'h0001);
    check("R7 tx irq disabled", tx_irq, 0);
    wr(2'd0, 16'h0003);
    repeat (50) @(negedge clk);
    check("R8 no frame while disabled", {nframes[15:0], 15'd0, sfrm}, 32'd0);

    chk_edges = 1; chk_half = 1; exp_lead = 4; exp_tail = 2; exp_half = 2;
    wr(2'd1, 16'h1701);
    repeat (300) @(negedge clk);
    check("R8 consecutive frames", nframes, 5);
    check("R3 idle low", sclk, 0);
    check("R6 rx irq at 5", rx_irq, 1);
    wr(2'd0, 16'h0002);
    check("R6 rx irq disabled", rx_irq, 0);
    wr(2'd0, 16'h0003);
    pop_chk("R5 rx word");
    pop_chk("R5 rx word");
    check("R6 rx irq at 3", rx_irq, 1);
    pop_chk("R5 rx word");
    check("R6 rx irq at 2", rx_irq, 0);
    drain("R5 rx word");

    // phase 1, idle high, 16 bits, N=2
    nbits = 16; pol = 1; pha = 1;
    exp_lead = 3; exp_tail = 6; exp_half = 3;
    wr(2'd0, 16'h0018);
    check("R3 idle high", sclk, 1);
    wr(2'd1, 16'h1F02);
    send(16'hB2C5, 16'h5A69);
    send(16'h8001, 16'hFFFE);
    repeat (300) @(negedge clk);
    check("R3 idle high after frames", sclk, 1);
    drain("R5 rx word phase 1");

    // clamped length: field 1 gives 4 bits
    nbits = 4; pol = 0; pha = 0;
    exp_lead = 4; exp_tail = 2; exp_half = 2;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h1101);
    send(16'h00A5, 16'h000C);
    repeat (60) @(negedge clk);
    drain("R5 4-bit frame");

    // R9 loopback
    nbits = 16; chk_edges = 0; chk_half = 0;
    begin
      int f0;
      f0 = nframes;
      wr(2'd0, 16'h0004);
      wr(2'd1, 16'h1F01);
      send_lb(16'h1234);
      repeat (10) @(negedge clk);
      check("R9 pins quiet", {pad_oe, sclk, sfrm, txd}, 4'b0000);
      repeat (120) @(negedge clk);
      check("R9 no frame on pins", nframes, f0);
      drain("R9 loopback word");
    end

    // R11 external clock
    nbits = 8; pol = 0; pha = 0;
    chk_half = 1; exp_half = 8;
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h17FF);
    send(16'h003C, 16'h0081);
    repeat (400) @(negedge clk);
    check("R11 frame done", nframes, 9);
    drain("R11 rx word");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule